// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block produces the timing skeleton of one successive-approximation analog-to-digital conversion. It turns the system clock into a conversion-clock strobe using one of eight division ratios. Each conversion is a chain of phases counted in strobes: an optional supply-settling wait, a sampling window and a bit-decision window. A one-cycle completion pulse closes the conversion. A stub successive-approximation model can follow the phase outputs and the strobe, so the comparator, DAC and result storage stay outside this block.

A conversion is requested by a software start pulse or, in the trigger-wait setting, by a hardware trigger pulse. In the trigger-wait setting the first conversion after the trigger is preceded by a short settling wait. With repeat selected, conversions follow one another back to back. Later conversions get no settling wait, and a flag marks which conversion is the first. The configuration can only be loaded while the block is disabled and no start is asserted. Dropping the enable abandons the work in progress at once.

Top module: `convtime_seq`

## Requirements
- R1: Divider code `cfg_div_sel` values 0..7 select ratios 64, 32, 16, 8, 6, 5, 4, 2. `cclk_en` is a one-cycle strobe once every ratio system clocks, including the odd ratio 5.
- R2: Voltage code 0, and the reserved codes 2 and 3 on `cfg_lv_sel`, give 7 sampling strobes and 19 strobes in total for a 10-bit conversion.
- R3: Voltage code 1 gives 5 sampling strobes and 17 strobes in total for a 10-bit conversion.
- R4: `cfg_res8`=1 selects 8-bit resolution, which takes 2 strobes fewer in the bit-decision phase than 10-bit.
- R5: With `cfg_trig_wait`=1, the request is `hw_trig` and the first conversion begins with a 2-strobe settling phase on `ph_stab`. With `cfg_trig_wait`=0, the request is `start`, `hw_trig` has no effect, and there is no settling phase. At most one phase output is high at a time.
- R6: A request is taken at a clock edge while idle and enabled. `conv_done` is high for exactly one cycle, beginning total-strobes × ratio cycles after that edge, and only after a bit-decision phase.
- R7: With `cfg_repeat`=1, the next conversion starts at once in the sampling phase with no settling wait. `first_conv` is high during the first conversion only.
- R8: A configuration write (`cfg_we`) takes effect only when `en` and `start` are both low. Otherwise it is ignored.
- R9: `en`=0 returns the block to idle on the next edge, with no `conv_done` and with `first_conv` high again.
- R10: After reset the block is idle, all phase outputs and `conv_done` are low, and `first_conv` is high. The configuration is divider code 0, voltage code 0, 10-bit, software start, single conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_div_sel | input | 3 | Division ratio code |
| cfg_lv_sel | input | 2 | Voltage mode code |
| cfg_res8 | input | 1 | 1 = 8-bit, 0 = 10-bit |
| cfg_trig_wait | input | 1 | 1 = hardware trigger with settling wait |
| cfg_repeat | input | 1 | 1 = back-to-back conversions |
| en | input | 1 | Converter enable; low aborts |
| start | input | 1 | Software start request |
| hw_trig | input | 1 | Hardware trigger request |
| cclk_en | output | 1 | Conversion-clock strobe |
| ph_stab | output | 1 | Settling phase active |
| ph_samp | output | 1 | Sampling phase active |
| ph_conv | output | 1 | Bit-decision phase active |
| first_conv | output | 1 | Current or next conversion is the first |
| conv_done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: a 2-strobe settling wait, 7 or 5 sampling strobes, 12 bit-decision strobes at full resolution and a 2-strobe cut for 8 bits. With these values every divider code can be measured end to end. The slowest case, ratio 64 with a settling wait, completes within about 1400 cycles, so the bench covers all eight ratios, both voltage codes, the reserved codes, both resolutions and both request sources. The same values let the bench check the exact gap between repeated conversions and the odd-ratio strobe spacing.

// File: rtl/convtime_pkg.sv
package convtime_pkg;

    localparam int MAX_RATIO = 64;
    localparam int DIV_CNT_W = $clog2(MAX_RATIO);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_STAB = 2'd1,
        PH_SAMP = 2'd2,
        PH_CONV = 2'd3
    } phase_e;

    typedef struct packed {
        logic [2:0] div_sel;
        logic       lv2;
        logic       res8;
        logic       trig_wait;
        logic       repeat_on;
    } cfg_t;

    function automatic logic [DIV_CNT_W:0] ratio_of(input logic [2:0] code);
        logic [DIV_CNT_W:0] r;
        case (code)
            3'd0:    r = (DIV_CNT_W+1)'(64);
            3'd1:    r = (DIV_CNT_W+1)'(32);
            3'd2:    r = (DIV_CNT_W+1)'(16);
            3'd3:    r = (DIV_CNT_W+1)'(8);
            3'd4:    r = (DIV_CNT_W+1)'(6);
            3'd5:    r = (DIV_CNT_W+1)'(5);
            3'd6:    r = (DIV_CNT_W+1)'(4);
            default: r = (DIV_CNT_W+1)'(2);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/convtime_div.sv
module convtime_div #(
    parameter int CNT_W = convtime_pkg::DIV_CNT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic           restart,
    input  logic [CNT_W:0] ratio,
    output logic           tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   term;

    assign term = ratio - 1'b1;
    assign tick = run && (cnt == term[CNT_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst || !run || restart || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/convtime_fsm.sv
module convtime_fsm
    import convtime_pkg::*;
#(
    parameter int PH_W       = 5,
    parameter int STAB_TICKS = 2,
    parameter int SAMP_LV1   = 7,
    parameter int SAMP_LV2   = 5,
    parameter int BITS_HI    = 12,
    parameter int RES_CUT    = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   req,
    input  logic   tick,
    input  logic   trig_wait,
    input  logic   repeat_on,
    input  logic   lv2,
    input  logic   res8,
    output phase_e phase,
    output logic   first_conv,
    output logic   done,
    output logic   restart
);
    localparam logic USE_STAB = (STAB_TICKS > 0);

    phase_e          ph_q;
    logic [PH_W-1:0] pcnt;
    logic [PH_W-1:0] cur_len;
    logic            first_q;
    logic            done_q;
    logic            last;

    always_comb begin
        case (ph_q)
            PH_STAB: cur_len = PH_W'(STAB_TICKS);
            PH_SAMP: cur_len = lv2 ? PH_W'(SAMP_LV2) : PH_W'(SAMP_LV1);
            default: cur_len = res8 ? PH_W'(BITS_HI - RES_CUT) : PH_W'(BITS_HI);
        endcase
    end

    assign last    = tick && (pcnt == cur_len - 1'b1);
    assign restart = en && (ph_q == PH_IDLE) && req;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_IDLE;
            pcnt    <= '0;
            first_q <= 1'b1;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!en) begin
                ph_q    <= PH_IDLE;
                pcnt    <= '0;
                first_q <= 1'b1;
            end else begin
                case (ph_q)
                    PH_IDLE: if (req) begin
                        ph_q    <= (trig_wait && USE_STAB) ? PH_STAB : PH_SAMP;
                        pcnt    <= '0;
                        first_q <= 1'b1;
                    end
                    PH_STAB, PH_SAMP: if (tick) begin
                        if (last) begin
                            ph_q <= (ph_q == PH_STAB) ? PH_SAMP : PH_CONV;
                            pcnt <= '0;
                        end else begin
                            pcnt <= pcnt + 1'b1;
                        end
                    end
                    default: if (tick) begin
                        if (last) begin
                            done_q <= 1'b1;
                            pcnt   <= '0;
                            if (repeat_on) begin
                                ph_q    <= PH_SAMP;
                                first_q <= 1'b0;
                            end else begin
                                ph_q    <= PH_IDLE;
                                first_q <= 1'b1;
                            end
                        end else begin
                            pcnt <= pcnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    assign phase      = ph_q;
    assign first_conv = first_q;
    assign done       = done_q;
endmodule

// File: rtl/convtime_seq.sv
module convtime_seq
    import convtime_pkg::*;
#(
    parameter int STAB_TICKS = 2,
    parameter int SAMP_LV1   = 7,
    parameter int SAMP_LV2   = 5,
    parameter int BITS_HI    = 12,
    parameter int RES_CUT    = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [2:0] cfg_div_sel,
    input  logic [1:0] cfg_lv_sel,
    input  logic       cfg_res8,
    input  logic       cfg_trig_wait,
    input  logic       cfg_repeat,
    input  logic       en,
    input  logic       start,
    input  logic       hw_trig,
    output logic       cclk_en,
    output logic       ph_stab,
    output logic       ph_samp,
    output logic       ph_conv,
    output logic       first_conv,
    output logic       conv_done
);
    localparam int LONGEST = (SAMP_LV1 > BITS_HI) ? SAMP_LV1 : BITS_HI;
    localparam int PH_W    = $clog2(LONGEST + STAB_TICKS + SAMP_LV2 + 1);

    cfg_t   cfg_q;
    phase_e phase;
    logic   tick;
    logic   req;
    logic   restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we && !en && !start) begin
            cfg_q.div_sel   <= cfg_div_sel;
            cfg_q.lv2       <= (cfg_lv_sel == 2'd1);
            cfg_q.res8      <= cfg_res8;
            cfg_q.trig_wait <= cfg_trig_wait;
            cfg_q.repeat_on <= cfg_repeat;
        end
    end

    assign req = cfg_q.trig_wait ? hw_trig : start;

    convtime_div #(.CNT_W(DIV_CNT_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (en),
        .restart (restart),
        .ratio   (ratio_of(cfg_q.div_sel)),
        .tick    (tick)
    );

    convtime_fsm #(
        .PH_W       (PH_W),
        .STAB_TICKS (STAB_TICKS),
        .SAMP_LV1   (SAMP_LV1),
        .SAMP_LV2   (SAMP_LV2),
        .BITS_HI    (BITS_HI),
        .RES_CUT    (RES_CUT)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .req        (req),
        .tick       (tick),
        .trig_wait  (cfg_q.trig_wait),
        .repeat_on  (cfg_q.repeat_on),
        .lv2        (cfg_q.lv2),
        .res8       (cfg_q.res8),
        .phase      (phase),
        .first_conv (first_conv),
        .done       (conv_done),
        .restart    (restart)
    );

    assign cclk_en = tick;
    assign ph_stab = (phase == PH_STAB);
    assign ph_samp = (phase == PH_SAMP);
    assign ph_conv = (phase == PH_CONV);
endmodule

// File: rtl/convtime_chk.sv
module convtime_chk
    import convtime_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic en,
    input logic cclk_en,
    input logic ph_stab,
    input logic ph_samp,
    input logic ph_conv,
    input logic first_conv,
    input logic conv_done,
    input cfg_t cfg_now
);
    a_r1_strobe_single: assert property (@(posedge clk) disable iff (rst)
        cclk_en |=> !cclk_en);

    a_r4_done_after_conv: assert property (@(posedge clk) disable iff (rst)
        conv_done |-> $past(ph_conv));

    a_r5_phase_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ph_stab, ph_samp, ph_conv}));

    a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        conv_done |=> !conv_done);

    a_r7_stab_first_only: assert property (@(posedge clk) disable iff (rst)
        ph_stab |-> first_conv);

    a_r8_cfg_locked: assert property (@(posedge clk) disable iff (rst)
        en |=> $stable(cfg_now));

    a_r9_abort_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!ph_stab && !ph_samp && !ph_conv && !conv_done && first_conv));
endmodule

bind convtime_seq convtime_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .cclk_en    (cclk_en),
    .ph_stab    (ph_stab),
    .ph_samp    (ph_samp),
    .ph_conv    (ph_conv),
    .first_conv (first_conv),
    .conv_done  (conv_done),
    .cfg_now    (cfg_q)
);

// File: tb/tb_convtime_seq.sv
module tb_convtime_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_div_sel = '0;
    logic [1:0] cfg_lv_sel = '0;
    logic       cfg_res8 = 1'b0;
    logic       cfg_trig_wait = 1'b0;
    logic       cfg_repeat = 1'b0;
    logic       en = 1'b0;
    logic       start = 1'b0;
    logic       hw_trig = 1'b0;
    logic       cclk_en, ph_stab, ph_samp, ph_conv, first_conv, conv_done;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    convtime_seq dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_div_sel(cfg_div_sel),
        .cfg_lv_sel(cfg_lv_sel), .cfg_res8(cfg_res8), .cfg_trig_wait(cfg_trig_wait),
        .cfg_repeat(cfg_repeat), .en(en), .start(start), .hw_trig(hw_trig),
        .cclk_en(cclk_en), .ph_stab(ph_stab), .ph_samp(ph_samp), .ph_conv(ph_conv),
        .first_conv(first_conv), .conv_done(conv_done)
    );

    typedef struct packed {
        logic [2:0]  div;
        logic [1:0]  lv;
        logic        res8;
        logic        hw;
        logic [15:0] cycles;
    } vec_t;

    // cycles = (settle + sample + bits) * ratio
    localparam vec_t VECS [8] = '{
        '{3'd7, 2'd0, 1'b0, 1'b0, 16'd38},    // R1 R2: 19*2
        '{3'd6, 2'd1, 1'b0, 1'b0, 16'd68},    // R3: 17*4
        '{3'd5, 2'd0, 1'b1, 1'b0, 16'd85},    // R4: 17*5
        '{3'd4, 2'd1, 1'b1, 1'b1, 16'd102},   // R5: (2+5+10)*6
        '{3'd3, 2'd0, 1'b0, 1'b1, 16'd168},   // R5: 21*8
        '{3'd0, 2'd2, 1'b1, 1'b0, 16'd1088},  // R2 reserved: 17*64
        '{3'd1, 2'd3, 1'b0, 1'b1, 16'd672},   // R2 reserved: 21*32
        '{3'd2, 2'd1, 1'b0, 1'b0, 16'd272}    // R3: 17*16
    };

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_cfg(input logic [2:0] d, input logic [1:0] lv, input logic r8,
                            input logic hw, input logic rep);
        @(negedge clk);
        en = 1'b0; start = 1'b0;
        cfg_we = 1'b1; cfg_div_sel = d; cfg_lv_sel = lv; cfg_res8 = r8;
        cfg_trig_wait = hw; cfg_repeat = rep;
        @(negedge clk);
        cfg_we = 1'b0;
        en = 1'b1;
    endtask

    // Issues a request and returns the cycle count to conv_done, left at the
    // falling edge where conv_done is first seen.
    task automatic run_one(input logic hw, input string req, output int k);
        logic seen;
        @(negedge clk);
        if (hw) hw_trig = 1'b1; else start = 1'b1;
        @(negedge clk);
        hw_trig = 1'b0; start = 1'b0;
        chk(first_conv === 1'b1, "R7 first flag at start", int'(first_conv), 1);
        chk(ph_stab === hw, "R5 settling phase on entry", int'(ph_stab), int'(hw));
        k = 0; seen = 1'b0;
        while (!seen && k < 4000) begin
            @(negedge clk);
            k++;
            if (conv_done) seen = 1'b1;
        end
    endtask

    task automatic wait_done(output int k);
        logic seen;
        k = 0; seen = 1'b0;
        while (!seen && k < 4000) begin
            @(negedge clk);
            k++;
            if (conv_done) seen = 1'b1;
        end
    endtask

    initial begin
        #600000;
        failures++; checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int k;
        int cnt;
        logic dbl, prev, bad;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk({ph_stab, ph_samp, ph_conv} === 3'b000, "R10 phases idle", int'({ph_stab, ph_samp, ph_conv}), 0);
        chk(conv_done === 1'b0, "R10 done low", int'(conv_done), 0);
        chk(first_conv === 1'b1, "R10 first flag", int'(first_conv), 1);

        // R10 default config: code 0, mode 1, 10-bit, software start: 19*64
        en = 1'b1;
        run_one(1'b0, "R10", k);
        chk(k == 1216, "R10 default timing", k, 1216);

        // Table walk: R1 R2 R3 R4 R5 R6
        foreach (VECS[i]) begin
            load_cfg(VECS[i].div, VECS[i].lv, VECS[i].res8, VECS[i].hw, 1'b0);
            run_one(VECS[i].hw, "R6", k);
            chk(k == int'(VECS[i].cycles), "R6 done timing", k, int'(VECS[i].cycles));
            @(negedge clk);
            chk(conv_done === 1'b0, "R6 done one cycle", int'(conv_done), 0);
            chk(ph_samp === 1'b0 && ph_conv === 1'b0, "R6 idle after single", int'({ph_samp, ph_conv}), 0);
        end

        // R7 repeat: ratio 2, mode 2, 8-bit, trigger wait
        load_cfg(3'd7, 2'd1, 1'b1, 1'b1, 1'b1);
        run_one(1'b1, "R7", k);
        chk(k == 34, "R7 first conversion with settling", k, 34);
        chk(first_conv === 1'b0, "R7 first flag clears", int'(first_conv), 0);
        chk(ph_samp === 1'b1, "R7 back to sampling", int'(ph_samp), 1);
        wait_done(k);
        chk(k == 30, "R7 gap without settling", k, 30);

        // R9 abort in mid-conversion
        repeat (7) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk({ph_stab, ph_samp, ph_conv} === 3'b000, "R9 idle after abort", int'({ph_stab, ph_samp, ph_conv}), 0);
        chk(first_conv === 1'b1, "R9 first re-armed", int'(first_conv), 1);
        en = 1'b1;
        bad = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (conv_done || ph_samp || ph_conv) bad = 1'b1;
        end
        chk(!bad, "R9 no done after abort", int'(bad), 0);

        // R8 write while enabled is ignored (still ratio 2, 8-bit, mode 2)
        @(negedge clk);
        cfg_we = 1'b1; cfg_div_sel = 3'd0; cfg_lv_sel = 2'd0; cfg_res8 = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_repeat = 1'b0;
        run_one(1'b1, "R8", k);
        chk(k == 34, "R8 write with en high ignored", k, 34);

        // R8 write while start high is ignored
        @(negedge clk);
        en = 1'b0; start = 1'b1; cfg_we = 1'b1; cfg_div_sel = 3'd0;
        @(negedge clk);
        cfg_we = 1'b0; start = 1'b0;
        @(negedge clk);
        en = 1'b1;
        run_one(1'b1, "R8", k);
        chk(k == 34, "R8 write with start high ignored", k, 34);

        // R5 hw_trig has no effect in software-start setting
        load_cfg(3'd7, 2'd0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        hw_trig = 1'b1;
        @(negedge clk);
        hw_trig = 1'b0;
        bad = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (ph_stab || ph_samp || ph_conv || conv_done) bad = 1'b1;
        end
        chk(!bad, "R5 hw_trig ignored in software mode", int'(bad), 0);

        // R1 odd ratio 5 strobe spacing
        load_cfg(3'd5, 2'd0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0; dbl = 1'b0; prev = 1'b0;
        for (int i = 0; i < 50; i++) begin
            if (cclk_en) cnt++;
            if (cclk_en && prev) dbl = 1'b1;
            prev = cclk_en;
            @(negedge clk);
        end
        chk(cnt == 10, "R1 ratio 5 strobe count", cnt, 10);
        chk(!dbl, "R1 single-cycle strobe", int'(dbl), 0);
        en = 1'b0;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule